// File: doc/BRIEF.md
# Sixteen-Function Bitwise Logic Unit

This block is a purely combinational bitwise logic stage with a parameterised data width. Two operands, `a_i` and `b_i`, enter together with a 4-bit function code `op_i`. The code selects one of the sixteen Boolean functions of two inputs, and the block applies that function to every bit position independently. The result appears on `f_o` with no clock and no storage.

The unit sits next to an arithmetic stage inside an arithmetic/logic/shift datapath. A downstream result multiplexer picks either its output or the arithmetic result. The code-to-function assignment is fixed. The four operand-pair minterms map to the four bits of the code, so any function can be requested by writing out its truth table as the code. A build parameter chooses between two equivalent gate structures: a sum of minterms, or a per-bit 4:1 multiplexer indexed by the operand pair.

Top module: `logic_microop_unit`

## Requirements
- R1: Code 4'd0 drives every bit of `f_o` to 0, and code 4'd15 drives every bit to 1, whatever the operands are.
- R2: Code 4'd1 gives `a_i & b_i`, code 4'd7 gives `a_i | b_i`, code 4'd6 gives `a_i ^ b_i`, and code 4'd9 gives `~(a_i ^ b_i)`.
- R3: Code 4'd2 gives `a_i & ~b_i`, which clears the bits of A where B is 1. Code 4'd4 gives `~a_i & b_i`, which clears the bits of B where A is 1.
- R4: Code 4'd3 passes `a_i` to `f_o` unchanged, and code 4'd5 passes `b_i` unchanged.
- R5: Code 4'd8 gives NOR, code 4'd14 gives NAND, code 4'd10 gives `~b_i`, and code 4'd12 gives `~a_i`.
- R6: Code 4'd11 gives `a_i | ~b_i`, which sets the bits of A where B is 0. Code 4'd13 gives `~a_i | b_i`, which sets the bits of B where A is 0.
- R7: For every code and every bit position i, `f_o[i]` equals `op_i[{~a_i[i], ~b_i[i]}]`. So code bit 3 is the output for the pair (A=0,B=0), bit 2 for (0,1), bit 1 for (1,0) and bit 0 for (1,1). Each bit depends only on the operand bits at its own position.
- R8: The output settles to the new value in the same time step that any input changes. There is no register and no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| op_i | input | 4 | Function code; its bits are the truth table of the selected function |
| f_o | output | WIDTH | Bitwise result |

## Verification
The assertions assume that `a_i`, `b_i` and `op_i` hold known 0/1 values whenever the checker evaluates. They also assume all three inputs change together in one update, so the result is judged only after the combinational logic has settled. The stimulus meets both assumptions. Every input is driven from a single process with full two-state values, including the random words drawn from a fixed seed. Each result is read half a clock period after the inputs were applied.

// File: rtl/lmu_pkg.sv
package lmu_pkg;

    // Function codes; each value is also the truth table of the function
    typedef enum logic [3:0] {
        LMU_ZERO      = 4'd0,
        LMU_AND       = 4'd1,
        LMU_A_ANDN_B  = 4'd2,
        LMU_PASS_A    = 4'd3,
        LMU_NA_AND_B  = 4'd4,
        LMU_PASS_B    = 4'd5,
        LMU_XOR       = 4'd6,
        LMU_OR        = 4'd7,
        LMU_NOR       = 4'd8,
        LMU_XNOR      = 4'd9,
        LMU_NOT_B     = 4'd10,
        LMU_A_ORN_B   = 4'd11,
        LMU_NOT_A     = 4'd12,
        LMU_NA_OR_B   = 4'd13,
        LMU_NAND      = 4'd14,
        LMU_ONES      = 4'd15
    } lmu_op_e;

    localparam int LMU_CODE_W  = 4;
    localparam int LMU_PAIRS   = 4;
    localparam int LMU_IDX_W   = $clog2(LMU_PAIRS);

    // One operand bit pair at a single position
    typedef struct packed {
        logic a;
        logic b;
    } lmu_pair_t;

    // Gate structure choice for each bit cell
    typedef enum logic {
        LMU_IMPL_SOP = 1'b0,
        LMU_IMPL_MUX = 1'b1
    } lmu_impl_e;

    // Code bit index addressed by an operand pair: (0,0)->3 ... (1,1)->0
    function automatic logic [LMU_IDX_W-1:0] lmu_pair_index(input lmu_pair_t p);
        return {~p.a, ~p.b};
    endfunction

endpackage

// File: rtl/lmu_minterm.sv
module lmu_minterm
    import lmu_pkg::*;
(
    input  lmu_pair_t              pair_i,
    output logic [LMU_PAIRS-1:0]   mt_o
);
    // One-hot minterm: bit k is high when the pair selects code bit k
    always_comb begin
        mt_o[3] = ~pair_i.a & ~pair_i.b;
        mt_o[2] = ~pair_i.a &  pair_i.b;
        mt_o[1] =  pair_i.a & ~pair_i.b;
        mt_o[0] =  pair_i.a &  pair_i.b;
    end
endmodule

// File: rtl/lmu_bit_cell.sv
module lmu_bit_cell
    import lmu_pkg::*;
#(
    parameter lmu_impl_e IMPL = LMU_IMPL_SOP
)(
    input  lmu_pair_t               pair_i,
    input  logic [LMU_CODE_W-1:0]   code_i,
    output logic                    f_o
);
    generate
        if (IMPL == LMU_IMPL_SOP) begin : g_sop
            logic [LMU_PAIRS-1:0] mt;
            lmu_minterm u_mt (
                .pair_i (pair_i),
                .mt_o   (mt)
            );
            assign f_o = |(mt & code_i);
        end else begin : g_mux
            logic [LMU_IDX_W-1:0] idx;
            assign idx = lmu_pair_index(pair_i);
            assign f_o = code_i[idx];
        end
    endgenerate
endmodule

// File: rtl/logic_microop_unit.sv
module logic_microop_unit
    import lmu_pkg::*;
#(
    parameter int        WIDTH = 8,
    parameter lmu_impl_e IMPL  = LMU_IMPL_SOP
)(
    input  logic [WIDTH-1:0]        a_i,
    input  logic [WIDTH-1:0]        b_i,
    input  logic [LMU_CODE_W-1:0]   op_i,
    output logic [WIDTH-1:0]        f_o
);
    localparam int LANES = WIDTH;

    lmu_pair_t [LANES-1:0] pairs;

    genvar i;
    generate
        for (i = 0; i < LANES; i++) begin : g_lane
            assign pairs[i] = '{a: a_i[i], b: b_i[i]};
            lmu_bit_cell #(.IMPL(IMPL)) u_cell (
                .pair_i (pairs[i]),
                .code_i (op_i),
                .f_o    (f_o[i])
            );
        end
    endgenerate
endmodule

// File: rtl/lmu_checker.sv
module lmu_checker
    import lmu_pkg::*;
#(
    parameter int WIDTH = 8
)(
    input logic [WIDTH-1:0]        a_i,
    input logic [WIDTH-1:0]        b_i,
    input logic [LMU_CODE_W-1:0]   op_i,
    input logic [WIDTH-1:0]        f_o
);
    always_comb begin
        if (!$isunknown({a_i, b_i, op_i})) begin
            for (int k = 0; k < WIDTH; k++) begin
                AST_TRUTH_TABLE_BIT: assert (f_o[k] == op_i[{~a_i[k], ~b_i[k]}]); // R7
            end
            if (op_i == LMU_ZERO)   AST_CLEAR_ALL:  assert (f_o == '0);          // R1
            if (op_i == LMU_ONES)   AST_SET_ALL:    assert (f_o == '1);          // R1
            if (op_i == LMU_XOR)    AST_XOR_OUT:    assert (f_o == (a_i ^ b_i)); // R2
            if (op_i == LMU_A_ANDN_B) AST_SEL_CLR_A: assert ((f_o & b_i) == '0); // R3
            if (op_i == LMU_PASS_A) AST_PASS_A:     assert (f_o == a_i);         // R4
            if (op_i == LMU_PASS_B) AST_PASS_B:     assert (f_o == b_i);         // R4
            if (op_i == LMU_NOT_A)  AST_INVERT_A:   assert (f_o == ~a_i);        // R5
            if (op_i == LMU_A_ORN_B) AST_SEL_SET_A: assert ((f_o | b_i) == '1);  // R6
        end
    end
endmodule

bind logic_microop_unit lmu_checker #(.WIDTH(WIDTH)) u_lmu_checker (
    .a_i  (a_i),
    .b_i  (b_i),
    .op_i (op_i),
    .f_o  (f_o)
);

// File: tb/tb_logic_microop_unit.sv
`timescale 1ns/1ps
module tb_logic_microop_unit;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic [W-1:0] a, b, f;
    logic [3:0]   op;
    int           n_checks = 0;
    int           n_fail = 0;
    bit           done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    logic_microop_unit #(.WIDTH(W)) dut (
        .a_i  (a),
        .b_i  (b),
        .op_i (op),
        .f_o  (f)
    );

    // Expected result written per named function
    function automatic logic [W-1:0] ref_named(input logic [3:0] c,
                                               input logic [W-1:0] x,
                                               input logic [W-1:0] y);
        case (c)
            4'd0:  return '0;
            4'd1:  return x & y;
            4'd2:  return x & ~y;
            4'd3:  return x;
            4'd4:  return ~x & y;
            4'd5:  return y;
            4'd6:  return x ^ y;
            4'd7:  return x | y;
            4'd8:  return ~(x | y);
            4'd9:  return ~(x ^ y);
            4'd10: return ~y;
            4'd11: return x | ~y;
            4'd12: return ~x;
            4'd13: return ~x | y;
            4'd14: return ~(x & y);
            default: return '1;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] c);
        case (c)
            4'd0, 4'd15:               return "R1";
            4'd1, 4'd7, 4'd6, 4'd9:    return "R2";
            4'd2, 4'd4:                return "R3";
            4'd3, 4'd5:                return "R4";
            4'd8, 4'd14, 4'd10, 4'd12: return "R5";
            default:                   return "R6";
        endcase
    endfunction

    task automatic check(input string req, input logic [W-1:0] got,
                         input logic [W-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s op=%0d a=%h b=%h got=%h expected=%h",
                     req, op, a, b, got, exp);
        end
    endtask

    task automatic apply(input logic [3:0] c, input logic [W-1:0] x,
                         input logic [W-1:0] y);
        @(posedge clk);
        op = c; a = x; b = y;
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd1234));
        a = '0; b = '0; op = 4'd0;
        @(negedge clk);
        check("R1", f, '0);  // initial state: clear code with zero operands

        // Directed: all four operand pairs present in every code
        for (int c = 0; c < 16; c++) begin
            apply(c[3:0], 8'b1100_1100, 8'b1010_1010);
            check(req_of(c[3:0]), f, ref_named(c[3:0], a, b));
            apply(c[3:0], 8'h00, 8'hFF);
            check(req_of(c[3:0]), f, ref_named(c[3:0], a, b));
            apply(c[3:0], 8'hFF, 8'h00);
            check(req_of(c[3:0]), f, ref_named(c[3:0], a, b));
        end

        // R1 corners: clear and set ignore operands
        apply(4'd0, 8'hFF, 8'hFF); check("R1", f, 8'h00);
        apply(4'd15, 8'h00, 8'h00); check("R1", f, 8'hFF);

        // R7: truth-table index property, bit by bit
        for (int c = 0; c < 16; c++) begin
            for (int p = 0; p < 4; p++) begin
                logic [W-1:0] x, y, e;
                x = p[1] ? '1 : '0;
                y = p[0] ? '1 : '0;
                apply(c[3:0], x, y);
                for (int k = 0; k < W; k++) e[k] = c[{~x[k], ~y[k]}];
                check("R7", f, e);
            end
        end

        // R8: output tracks a mid-cycle input change with no clock edge
        op = 4'd6; a = 8'h5A; b = 8'h0F;
        #1;
        check("R8", f, 8'h55);
        a = 8'hF0;
        #1;
        check("R8", f, 8'hFF);

        // Random stimulus
        for (int n = 0; n < 3000; n++) begin
            logic [3:0] c;
            logic [W-1:0] x, y;
            c = 4'($urandom_range(0, 15));
            x = W'($urandom);
            y = W'($urandom);
            apply(c, x, y);
            check(req_of(c), f, ref_named(c, x, y));
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog expired got=running expected=done");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule